// File: doc/BRIEF.md
# Pulse-Width Carrier Detector

This block decides whether a radio channel carries a signal. Once every fixed measurement period (1 ms at the nominal clock), it fires a one-clock restart pulse that starts an external analog ramp. An external comparator then holds its output high for a time that grows with received signal strength. The block synchronises that comparator output and counts the clocks of its first high pulse in each period. At the end of the period it publishes the count with a one-clock valid strobe.

Each published width is compared with two loaded levels. While the channel is idle, reaching the open level marks it busy. While it is busy, only a width below the close level marks it idle again. The gap between the two levels gives the closing hysteresis. A change of state takes effect only after a set number of consecutive periods agree, so a single odd period has no effect.

Top module: `pw_carrier_det`

## Requirements
- R1: `ramp_restart_o` is high for exactly one clock in every `PERIOD_CLKS` clocks. The first such clock is the first clock after reset is released.
- R2: The comparator input passes through two flip-flop stages before use. The published width equals the number of clocks for which the first high pulse of `cmp_i` lasted within the period.
- R3: The width saturates at 2^`CNT_W`-1 and does not wrap.
- R4: After the first falling edge of the synchronised comparator in a period, any later high pulses in that period add nothing to the width.
- R5: `width_vld_o` is high for one clock, in the restart clock that follows each period. `width_o` changes only in that clock and holds its value otherwise.
- R6: While idle, a width greater than or equal to `open_lvl_i` is a vote for busy.
- R7: While busy, a width less than `close_lvl_i` is a vote for idle. A width equal to or above `close_lvl_i` is a vote to stay busy.
- R8: `busy_o` changes only after `CONFIRM_N` (default 2) consecutive votes for the other state. The change takes effect in the clock after the valid strobe. Any vote for the current state resets the run.
- R9: After reset, `busy_o`, `width_vld_o` and `width_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Asynchronous comparator output; high while the ramp is below signal strength |
| open_lvl_i | input | CNT_W | Width at or above which an idle channel becomes busy |
| close_lvl_i | input | CNT_W | Width below which a busy channel becomes idle |
| ramp_restart_o | output | 1 | One-clock pulse starting each measurement period |
| width_o | output | CNT_W | Last measured pulse width in clocks |
| width_vld_o | output | 1 | One-clock strobe when `width_o` is updated |
| busy_o | output | 1 | Debounced carrier-present flag |

## Verification
Periods with a single clean pulse show that the width counts only the comparator's high time. Periods with a second pulse after a gap show that only the first pulse counts. Pulses longer than the counter range show that the count saturates. Width sequences placed just above, exactly at and just below each level are separate cases. Each is sent for one period and then for two periods in a row. Together they tell apart a threshold compare that is off by one, a hysteresis that uses the wrong level, and a debounce that acts on a single vote. A long run of random pulse lengths then checks every width and every busy transition against a reference model kept in the bench.

// File: rtl/pwcd_pkg.sv
package pwcd_pkg;
   typedef enum logic {
      CH_IDLE = 1'b0,
      CH_BUSY = 1'b1
   } chan_state_e;
endpackage

// File: rtl/pwcd_sync.sv
module pwcd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pwcd_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q[s] <= 1'b0;
            else         sh_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q[s] <= 1'b0;
            else         sh_q[s] <= sh_q[s-1];
         end
      end
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwcd_timebase.sv
module pwcd_timebase #(
   parameter int unsigned PERIOD_CLKS = 125000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic restart_o,
   output logic last_o
);
   localparam int unsigned TW = $clog2(PERIOD_CLKS);
   localparam logic [TW-1:0] LAST = TW'(PERIOD_CLKS - 1);

   if (PERIOD_CLKS < 8) begin : g_bad_period
      $error("pwcd_timebase: PERIOD_CLKS must be at least 8");
   end

   logic [TW-1:0] tick_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             tick_q <= '0;
      else if (tick_q == LAST) tick_q <= '0;
      else                     tick_q <= tick_q + 1'b1;
   end

   assign restart_o = (tick_q == '0);
   assign last_o    = (tick_q == LAST);

   // R1: restart never lasts two clocks, and always follows the period's last clock
   p_restart_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_o |=> !restart_o);
   p_last_then_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_o |=> restart_o);
endmodule

// File: rtl/pwcd_width_meas.sv
module pwcd_width_meas #(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lvl_i,
   input  logic             last_i,
   output logic [CNT_W-1:0] width_o,
   output logic             vld_o
);
   localparam logic [CNT_W-1:0] SAT = '1;

   logic             lvl_d_q, armed_q, vld_q;
   logic [CNT_W-1:0] acc_q, acc_nx, width_q;
   logic             hit, fall;

   assign hit  = armed_q & lvl_i;
   assign fall = lvl_d_q & ~lvl_i;

   always_comb begin
      acc_nx = acc_q;
      if (hit && acc_q != SAT) acc_nx = acc_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_d_q <= 1'b0;
         armed_q <= 1'b1;
         acc_q   <= '0;
         width_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         lvl_d_q <= lvl_i;
         vld_q   <= last_i;
         if (last_i) begin
            width_q <= acc_nx;
            acc_q   <= '0;
            armed_q <= 1'b1;
         end else begin
            acc_q <= acc_nx;
            if (armed_q && fall) armed_q <= 1'b0;
         end
      end
   end

   assign width_o = width_q;
   assign vld_o   = vld_q;

   // R3: a full accumulator stays full until the period closes
   p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_q == SAT && !last_i) |=> acc_q == SAT);
   // R4: once disarmed, nothing is added until the period closes
   p_ignore_after_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_q && !last_i) |=> $stable(acc_q));
   // R5: the strobe is single and the width holds between strobes
   p_vld_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |=> !vld_o);
   p_width_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_o |-> $stable(width_o));
endmodule

// File: rtl/pwcd_hyst.sv
module pwcd_hyst
   import pwcd_pkg::*;
#(
   parameter int unsigned CNT_W     = 17,
   parameter int unsigned CONFIRM_N = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vld_i,
   input  logic [CNT_W-1:0] width_i,
   input  logic [CNT_W-1:0] open_i,
   input  logic [CNT_W-1:0] close_i,
   output logic             busy_o
);
   chan_state_e state_q, vote;

   always_comb begin
      if (state_q == CH_IDLE) vote = (width_i >= open_i) ? CH_BUSY : CH_IDLE;
      else                    vote = (width_i <  close_i) ? CH_IDLE : CH_BUSY;
   end

   if (CONFIRM_N < 1) begin : g_bad_confirm
      $error("pwcd_hyst: CONFIRM_N must be at least 1");
   end

   if (CONFIRM_N == 1) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    state_q <= CH_IDLE;
         else if (vld_i) state_q <= vote;
      end
   end else begin : g_confirm
      localparam int unsigned RW = $clog2(CONFIRM_N);
      localparam logic [RW-1:0] RUN_LAST = RW'(CONFIRM_N - 1);
      logic [RW-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            state_q <= CH_IDLE;
            run_q   <= '0;
         end else if (vld_i) begin
            if (vote == state_q) begin
               run_q <= '0;
            end else if (run_q == RUN_LAST) begin
               state_q <= vote;
               run_q   <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end

      // R8: the first opposing vote of a run never flips the flag
      p_first_vote_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (vld_i && run_q == '0) |=> $stable(busy_o));
   end

   assign busy_o = (state_q == CH_BUSY);

   // R8: the flag moves only in the clock after a strobe
   p_move_after_vld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(busy_o) |-> $past(vld_i));
   // R6: becoming busy needs a width at or above the open level
   p_set_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(width_i >= open_i));
   // R7: becoming idle needs a width below the close level
   p_clear_close_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> $past(width_i < close_i));
endmodule

// File: rtl/pw_carrier_det.sv
module pw_carrier_det #(
   parameter int unsigned PERIOD_CLKS = 125000,
   parameter int unsigned CNT_W       = 17,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CONFIRM_N   = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmp_i,
   input  logic [CNT_W-1:0] open_lvl_i,
   input  logic [CNT_W-1:0] close_lvl_i,
   output logic             ramp_restart_o,
   output logic [CNT_W-1:0] width_o,
   output logic             width_vld_o,
   output logic             busy_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pw_carrier_det: CNT_W must lie in 2..32");
   end

   logic cmp_s, last_clk;

   pwcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (cmp_i),
      .q_o   (cmp_s)
   );

   pwcd_timebase #(.PERIOD_CLKS(PERIOD_CLKS)) u_timebase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_o(ramp_restart_o),
      .last_o   (last_clk)
   );

   pwcd_width_meas #(.CNT_W(CNT_W)) u_meas (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (cmp_s),
      .last_i (last_clk),
      .width_o(width_o),
      .vld_o  (width_vld_o)
   );

   pwcd_hyst #(.CNT_W(CNT_W), .CONFIRM_N(CONFIRM_N)) u_hyst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (width_vld_o),
      .width_i(width_o),
      .open_i (open_lvl_i),
      .close_i(close_lvl_i),
      .busy_o (busy_o)
   );

   // R5: a strobe appears only in a restart clock
   p_vld_on_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      width_vld_o |-> ramp_restart_o);
endmodule

// File: tb/pw_carrier_det_bench.sv
`timescale 1ns/1ps
module pw_carrier_det_bench;
   localparam int unsigned PER = 100;
   localparam int unsigned CW  = 6;
   localparam int unsigned MAXW = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, cmp = 1'b0;
   logic [CW-1:0] open_lvl = 6'd40, close_lvl = 6'd25;
   logic restart, vld, busy;
   logic [CW-1:0] width;

   int checks = 0, fails = 0;
   bit done = 0;
   bit model_busy = 0;
   int model_run = 0;
   int prev_w = -1;

   always #4 clk = ~clk;

   pw_carrier_det #(.PERIOD_CLKS(PER), .CNT_W(CW), .SYNC_STAGES(2), .CONFIRM_N(2))
   u_pw_carrier_det (
      .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp),
      .open_lvl_i(open_lvl), .close_lvl_i(close_lvl),
      .ramp_restart_o(restart), .width_o(width), .width_vld_o(vld), .busy_o(busy)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_width(input int h1);
      return (h1 > int'(MAXW)) ? int'(MAXW) : h1;
   endfunction

   function automatic bit vote(input bit cur, input int w);
      if (!cur) return w >= int'(open_lvl);
      return !(w < int'(close_lvl));
   endfunction

   // One period, entered and left at a negedge in which restart is high.
   task automatic period(input int h1, input int gap, input int h2);
      int n;
      if (prev_w >= 0) begin
         check("R8 busy", busy, model_busy);
         check("R5 valid", vld, 1);
         check("R2 width", width, prev_w);
         if (vote(model_busy, prev_w) == model_busy) model_run = 0;
         else if (model_run == 1) begin model_busy = !model_busy; model_run = 0; end
         else model_run++;
      end
      n = 0;
      forever begin
         cmp = (n < h1) || (n >= h1 + gap && n < h1 + gap + h2);
         @(negedge clk);
         n++;
         if (n == PER / 2) check("R5 no mid strobe", vld, 0);
         if (restart) break;
         if (n > 2 * PER) break;
      end
      check("R1 period", n, PER);
      prev_w = exp_width(h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R9 busy", busy, 0);
      check("R9 valid", vld, 0);
      check("R9 width", width, 0);
      rst_n = 1'b1;
      check("R1 first restart", restart, 1);
      period(0, 0, 0);
      period(45, 0, 0);   // R6 single vote, no effect (R8)
      period(10, 0, 0);
      period(45, 0, 0);   // R6 two votes set busy
      period(45, 0, 0);
      period(30, 0, 0);   // R7 between levels stays busy
      period(10, 0, 0);   // R8 single idle vote ignored
      period(30, 0, 0);
      period(10, 0, 0);
      period(10, 0, 0);   // R7 clears
      period(40, 0, 0);   // R6 equality sets
      period(40, 0, 0);
      period(25, 0, 0);   // R7 equality keeps busy
      period(25, 0, 0);
      period(24, 0, 0);
      period(24, 0, 0);
      period(80, 0, 0);   // R3 saturation
      period(90, 0, 0);
      period(20, 3, 30);  // R4 second pulse ignored
      period(5, 1, 60);
      for (int k = 0; k < 200; k++) begin
         int h1, g, h2;
         h1 = $urandom_range(1, 90);
         g  = 0; h2 = 0;
         if ($urandom_range(0, 3) == 0 && h1 < 80) begin
            g  = $urandom_range(1, 5);
            h2 = $urandom_range(1, 90 - h1 - g);
         end
         period(h1, g, h2);
      end
      period(0, 0, 0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule